// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces, one per clock, the column addresses of an SDRAM burst. A request carries a starting column, a burst-length code and an ordering bit. From the clock edge that accepts it, the block walks through the beats of the burst. At each beat it shows the current column, flags the final beat, and holds a busy indication for as long as the burst runs. It fits in a memory controller as the tracker of the column being transferred, and it also serves as a reference model for a bench that checks a memory device.

Two orderings are supported. In sequential order the low bits count upward and wrap inside the burst. In interleaved order the beat number is XORed into the low bits. A full-page length is also available: it steps through the whole 1024-column row, wraps around, and runs until a stop arrives. Full page is valid only with sequential order. A new request may arrive on any clock, and it replaces the burst in progress at once.

The column output forms a stream that is valid while `busy` is high. There is no ready signal: a burst cannot be held back, so the consumer must take one column on every clock in which `busy` is high. Control inputs are plain single-cycle pulses.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `busy`, `last` and `err` are all low.
- R2: A legal request (`start` high) makes `busy` high in the next cycle, with `col` equal to `start_col`. `len_code` selects the length: 0, 1, 2 and 3 give lengths 1, 2, 4 and 8; 7 gives full page; 4, 5 and 6 are reserved. `ilv` set to 0 selects sequential order and 1 selects interleaved order.
- R3: In sequential order, beat n shows the starting column with its low log2(length) bits replaced by (start low bits + n) modulo the length. The upper bits do not change.
- R4: In interleaved order, beat n shows the starting column with its low log2(length) bits replaced by (start low bits XOR n). The upper bits do not change.
- R5: A full-page burst advances the column by one each cycle, modulo 1024, and never raises `last`.
- R6: `last` is high on beat length-1. In the cycle after that beat, `busy` is low unless a new request was accepted.
- R7: `stop` without `start` ends the burst: `busy` is low in the next cycle.
- R8: A request accepted during a burst restarts the sequence from its own start column in the next cycle. When `start` and `stop` are high together, `start` wins.
- R9: A reserved length code, or full page together with interleaved order, is rejected. `err` is high for one cycle in the next cycle, and any burst in progress goes on unchanged.
- R10: `last` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; loads a new burst |
| start_col | input | 10 | Starting column of the request |
| len_code | input | 3 | Burst length code |
| ilv | input | 1 | Ordering: 0 sequential, 1 interleaved |
| stop | input | 1 | Ends the burst in progress |
| col | output | 10 | Column of the current beat |
| busy | output | 1 | A burst is in progress; `col` is valid |
| last | output | 1 | Current beat is the final one |
| err | output | 1 | Previous cycle's request was rejected |

## Verification
The checks run on every cycle cover the following: loading on a legal request, rejection of illegal requests, termination by stop, the drop of `busy` after the final beat, the absence of `last` in full page, the one-step increments of full page, and `last` only while busy. Other properties are shown only by the bench's scenarios. These are the exact beat orders for both orderings, the modulo wrap inside an aligned block, the 1023-to-0 wrap of full page, restart in mid-burst, the precedence of start over stop, and a burst surviving a rejected request.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  localparam int LEN_W   = 3;
  localparam int MAX_POW = 3;
  localparam logic [LEN_W-1:0] LEN_FULL = 3'd7;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;
endpackage

// File: rtl/bsq_cfg_decode.sv
module bsq_cfg_decode
  import bsq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [LEN_W-1:0] len_code,
  input  order_e           order,
  output logic [COL_W-1:0] mask,
  output logic             full,
  output logic             legal
);
  logic [COL_W-1:0] pow_mask;

  // one bit per column bit: set when the burst spans that bit
  for (genvar i = 0; i < COL_W; i++) begin : g_pow
    assign pow_mask[i] = (32'(len_code) > i);
  end

  always_comb begin
    full  = (len_code == LEN_FULL);
    mask  = '0;
    legal = 1'b0;
    if (full) begin
      mask  = '1;
      legal = (order == ORD_SEQ);
    end else if (32'(len_code) <= MAX_POW) begin
      mask  = pow_mask;
      legal = 1'b1;
    end
  end
endmodule

// File: rtl/bsq_burst_state.sv
module bsq_burst_state
  import bsq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             stop,
  input  logic [COL_W-1:0] base_in,
  input  logic [COL_W-1:0] mask_in,
  input  logic             full_in,
  input  order_e           order_in,
  output logic             busy,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] mask,
  output logic             full,
  output order_e           order,
  output logic             at_end
);
  assign at_end = busy && !full && (beat == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      beat  <= '0;
      base  <= '0;
      mask  <= '0;
      full  <= 1'b0;
      order <= ORD_SEQ;
    end else if (load) begin
      busy  <= 1'b1;
      beat  <= '0;
      base  <= base_in;
      mask  <= mask_in;
      full  <= full_in;
      order <= order_in;
    end else if (busy) begin
      if (stop || at_end) begin
        busy <= 1'b0;
        full <= 1'b0;
        beat <= '0;
      end else begin
        beat <= beat + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bsq_col_gen.sv
module bsq_col_gen
  import bsq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  order_e           order,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] sum;
  assign sum = base + beat;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col[i] = mask[i] ? ((order == ORD_ILV) ? (base[i] ^ beat[i]) : sum[i])
                            : base[i];
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bsq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [LEN_W-1:0] len_code,
  input  logic             ilv,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             busy,
  output logic             last,
  output logic             err
);
  logic [COL_W-1:0] dec_mask, base_q, mask_q, beat_q;
  logic             dec_full, dec_legal, load, full_q, at_end, err_q;
  order_e           req_order, order_q;

  assign req_order = order_e'(ilv);
  assign load      = start && dec_legal;

  bsq_cfg_decode #(.COL_W(COL_W)) u_dec (
    .len_code(len_code), .order(req_order),
    .mask(dec_mask), .full(dec_full), .legal(dec_legal)
  );

  bsq_burst_state #(.COL_W(COL_W)) u_state (
    .clk(clk), .rst_n(rst_n), .load(load), .stop(stop),
    .base_in(start_col), .mask_in(dec_mask), .full_in(dec_full), .order_in(req_order),
    .busy(busy), .beat(beat_q), .base(base_q), .mask(mask_q),
    .full(full_q), .order(order_q), .at_end(at_end)
  );

  bsq_col_gen #(.COL_W(COL_W)) u_gen (
    .base(base_q), .beat(beat_q), .mask(mask_q), .order(order_q), .col(col)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= start && !dec_legal;
  end

  assign err  = err_q;
  assign last = at_end;
endmodule

// File: rtl/bsq_chk.sv
module bsq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic [2:0]       len_code,
  input logic             ilv,
  input logic             stop,
  input logic [COL_W-1:0] col,
  input logic             busy,
  input logic             last,
  input logic             err,
  input logic             full_q
);
  logic req_ok;
  assign req_ok = (len_code <= 3'd3) || ((len_code == 3'd7) && !ilv);

  // R10
  last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n) last |-> busy);
  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && req_ok |=> busy && (col == $past(start_col)));
  // R9
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n) start && !req_ok |=> err);
  // R7
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n) stop && !start |=> !busy);
  // R6
  end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) last && !start |=> !busy);
  // R5
  full_nolast_chk: assert property (@(posedge clk) disable iff (!rst_n) full_q |-> !last);
  // R5
  full_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && full_q && !start && !stop |=> busy && (col == $past(col) + 1'b1));
endmodule

bind burst_col_seq bsq_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
  .len_code(len_code), .ilv(ilv), .stop(stop), .col(col), .busy(busy),
  .last(last), .err(err), .full_q(full_q)
);

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       start = 1'b0, ilv = 1'b0, stop = 1'b0;
  logic [9:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic [9:0] col;
  logic       busy, last, err;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  logic [10:0] q_exp[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  burst_col_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .ilv(ilv), .stop(stop),
    .col(col), .busy(busy), .last(last), .err(err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] beat_of(input logic [9:0] s, input int code,
                                          input bit il, input int n);
    logic [9:0] m, lo, c;
    bit fp;
    fp = (code == 7);
    m  = fp ? 10'h3FF : 10'((1 << code) - 1);
    lo = il ? (s ^ 10'(n)) : (s + 10'(n));
    c  = (s & ~m) | (lo & m);
    return {(!fp && (10'(n) == m)), c};
  endfunction

  // push n expected beats, then issue the request; returns with beat n-1 visible
  task automatic issue(input logic [9:0] s, input int code, input bit il,
                       input int n, input bit stp, input string tag);
    for (int k = 0; k < n; k++) begin
      q_exp.push_back(beat_of(s, code, il, k));
      q_tag.push_back(tag);
    end
    start_col = s; len_code = 3'(code); ilv = il; start = 1'b1; stop = stp;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic check_idle(input string tag);
    check(!busy && !last && q_exp.size() == 0, tag, {busy, last}, 0);
  endtask

  // monitor: compares every visible beat against the scoreboard
  always @(negedge clk) begin
    if (rst_n && busy) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R2 unexpected beat", {last, col}, 0);
      end else begin
        logic [10:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check({last, col} == e, t, {last, col}, e);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !last && !err, "R1 reset", {busy, last, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R6: sequential length 4 from 6 -> 6,7,4,5
    issue(10'h006, 2, 1'b0, 4, 1'b0, "R3 seq4");
    @(negedge clk); check_idle("R6 end seq4");

    // R4: interleaved length 8 from 3FD -> low bits 5,4,7,6,1,0,3,2
    issue(10'h3FD, 3, 1'b1, 8, 1'b0, "R4 ilv8");
    @(negedge clk); check_idle("R6 end ilv8");

    // R6: length 1
    issue(10'h155, 0, 1'b0, 1, 1'b0, "R6 len1");
    @(negedge clk); check_idle("R6 end len1");

    // R4: interleaved length 2
    issue(10'h00B, 1, 1'b1, 2, 1'b0, "R4 ilv2");
    @(negedge clk); check_idle("R6 end ilv2");

    // R5 R7: full page wraps past 1023, then stop
    issue(10'h3FC, 7, 1'b0, 8, 1'b0, "R5 full");
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    check_idle("R7 stop full");

    // R8: restart mid-burst, start wins over a simultaneous stop
    issue(10'h100, 3, 1'b0, 3, 1'b0, "R8 first");
    issue(10'h202, 2, 1'b1, 4, 1'b1, "R8 restart");
    @(negedge clk); check_idle("R8 end");

    // R7: stop at beat 2 of a length-8 burst
    issue(10'h2A8, 3, 1'b0, 3, 1'b0, "R7 seq8");
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    check_idle("R7 stop seq8");

    // R9: illegal full+interleave during a burst; burst keeps going
    for (int k = 0; k < 8; k++) begin
      q_exp.push_back(beat_of(10'h043, 3, 1'b0, k)); q_tag.push_back("R9 survive");
    end
    start_col = 10'h043; len_code = 3'd3; ilv = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    start_col = 10'h111; len_code = 3'd7; ilv = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(err == 1'b1, "R9 err full+ilv", err, 1);
    repeat (5) @(negedge clk);
    @(negedge clk);
    check_idle("R9 end");
    check(err == 1'b0, "R9 err one cycle", err, 0);

    // R9: reserved code while idle
    start_col = 10'h010; len_code = 3'd5; ilv = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(err == 1'b1 && !busy, "R9 reserved", {err, busy}, 2);
    @(negedge clk);
    check(err == 1'b0 && !busy, "R9 reserved clear", {err, busy}, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule